// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Generator

This block produces the four gate commands of a full-bridge inverter: a high-side and a low-side gate for each of the two bridge halves, called A and B. Both halves toggle as square waves with one shared period, and half B trails half A by a programmable number of clock cycles. The trailing amount, not a duty cycle, is the control quantity: it sets how long the two half-bridge voltages oppose each other and therefore the RMS voltage applied to the resonant load. A lamp-current loop outside this block adjusts the phase word, and an ignition sequencer walks the period word from short (high frequency) to long (low frequency).

Each half passes through a dead-time stage so that its two switches are never commanded together and a gap separates every hand-over. The gap is longer when the bridge runs from a high supply rail, selected by a configuration input. A sync pulse restarts the period so that several controllers fed the same pulse switch their A halves together, whatever phase each one is asked for. Period and phase words are captured only when a period begins, so a change mid-period never produces a runt pulse.

Top module: `fbridge_phase_gen`

## Requirements
- R1: A period lasts P clock cycles, where P is `periodIn` (raised to PER_MIN) as sampled in the cycle the period starts; `periodIn` and `phaseIn` are ignored at all other times, so a stepped ignition sweep takes effect one period at a time.
- R2: Half A wants its high side for the first floor(P/2) cycles of each period (counter value 0 .. floor(P/2)-1) and its low side for the remainder.
- R3: Half B wants its high side when (counter - ph) mod P is below floor(P/2), where ph is `phaseIn` clamped to floor(P/2); ph = 0 makes B identical to A.
- R4: Gate outputs are registered; a gate turns on only after its half's wanted level has held for D+1 consecutive active cycles, with D = 2 when `hvMode` is 0 (low-voltage supply) and D = 4 when `hvMode` is 1 (high-voltage supply), so each hand-over leaves both gates of that half low for exactly D cycles.
- R5: The high-side and low-side gate of the same half are never high together, and a gate that is high is followed by at least one cycle with the opposite gate low.
- R6: In the cycle after `runEn` is sampled low, all four gates are low and the counter is back at 0; when `runEn` returns high a new period starts one cycle later and the dead-time stages begin counting from scratch.
- R7: A `syncIn` high sampled while running starts a new period in the next cycle (counter 0, period and phase words resampled) without interrupting the dead-time history.
- R8: A `periodIn` below PER_MIN (default 8) is treated as PER_MIN.
- R9: While `rstN` is low, and after its release until a period is running, all four gates are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Run enable; low forces all gates low |
| hvMode | input | 1 | Supply configuration: 1 selects the longer dead time |
| syncIn | input | 1 | One-cycle pulse that restarts the period |
| periodIn | input | CNT_W | Period in clock cycles |
| phaseIn | input | CNT_W | Delay of half B behind half A in clock cycles |
| gateHiA | output | 1 | High-side gate, half A |
| gateLoA | output | 1 | Low-side gate, half A |
| gateHiB | output | 1 | High-side gate, half B |
| gateLoB | output | 1 | Low-side gate, half B |

## Verification
The bench targets phase words above half the period, which a missing clamp would turn into a B waveform that no longer has even duty; periods below the minimum, where a design without the floor would give pulses too short to survive the dead time; and period words that change mid-period, which a design sampling them continuously would turn into truncated or stretched pulses. It flips the supply configuration and measures the hand-over gap, which an off-by-one dead-time counter lengthens or shortens by a cycle, and fires sync pulses and enable drops at arbitrary counter values, where a design that failed to restart the counter or to clear the dead-time history would switch a gate on too early.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

  // Strobes from the sequencing control to the period datapath.
  typedef struct packed {
    logic start;  // begin a new period: zero counter, capture words
    logic clear;  // bridge disabled: hold counter at zero
  } fbgStrobe_t;

endpackage

// File: rtl/fbg_datapath.sv
module fbg_datapath
  import fbg_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int PER_MIN = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  fbgStrobe_t       strb,
  input  logic [CNT_W-1:0] periodIn,
  input  logic [CNT_W-1:0] phaseIn,
  output logic             lastTick,
  output logic             wantA,
  output logic             wantB
);

  localparam logic [CNT_W-1:0] PMIN  = CNT_W'(PER_MIN);
  localparam logic [CNT_W-1:0] HMIN  = CNT_W'(PER_MIN / 2);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] perReg;
  logic [CNT_W-1:0] halfReg;
  logic [CNT_W-1:0] phReg;

  logic [CNT_W-1:0] perEff;
  logic [CNT_W-1:0] halfEff;
  logic [CNT_W-1:0] phEff;
  logic [CNT_W:0]   posB;

  // Words that will be captured if a period starts this cycle.
  always_comb begin
    perEff  = (periodIn < PMIN) ? PMIN : periodIn;
    halfEff = perEff >> 1;
    phEff   = (phaseIn > halfEff) ? halfEff : phaseIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      perReg  <= PMIN;
      halfReg <= HMIN;
      phReg   <= '0;
    end else if (strb.clear) begin
      cnt     <= '0;
    end else if (strb.start) begin
      cnt     <= '0;
      perReg  <= perEff;
      halfReg <= halfEff;
      phReg   <= phEff;
    end else begin
      cnt     <= cnt + 1'b1;
    end
  end

  // Position of half B inside its own (delayed) period.
  always_comb begin
    if (cnt >= phReg) begin
      posB = {1'b0, cnt} - {1'b0, phReg};
    end else begin
      posB = {1'b0, cnt} + {1'b0, perReg} - {1'b0, phReg};
    end
  end

  assign lastTick = (cnt == perReg - 1'b1);
  assign wantA    = (cnt < halfReg);
  assign wantB    = (posB < {1'b0, halfReg});

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt < perReg);

  // R3
  phase_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    phReg <= (perReg >> 1));

  // R8
  per_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    perReg >= PMIN);

  // R1
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.start |=> $stable(perReg) && $stable(phReg));

endmodule

// File: rtl/fbg_ctrl.sv
module fbg_ctrl
  import fbg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic       syncIn,
  input  logic       lastTick,
  output fbgStrobe_t strb,
  output logic       legActive
);

  logic running;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
    end else begin
      running <= runEn;
    end
  end

  always_comb begin
    strb.clear = !runEn;
    strb.start = runEn && (!running || syncIn || lastTick);
    legActive  = runEn && running;
  end

  // R6
  restart_after_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !running) |=> running);

endmodule

// File: rtl/fbg_leg.sv
module fbg_leg #(
  parameter int DT_LV = 2,
  parameter int DT_HV = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic active,
  input  logic hvMode,
  input  logic want,
  output logic gateHi,
  output logic gateLo
);

  localparam int DT_MAX = (DT_HV > DT_LV) ? DT_HV : DT_LV;
  localparam int RUN_W  = $clog2(DT_MAX + 1);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(DT_MAX);

  logic             prevW;
  logic             prevAct;
  logic [RUN_W-1:0] runLen;
  logic [RUN_W-1:0] runNext;
  logic [RUN_W-1:0] dtNow;
  logic             settled;

  always_comb begin
    dtNow = hvMode ? RUN_W'(DT_HV) : RUN_W'(DT_LV);
    if (prevAct && (want == prevW)) begin
      runNext = (runLen == RUN_SAT) ? runLen : runLen + 1'b1;
    end else begin
      runNext = '0;
    end
    settled = (runNext >= dtNow);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevW   <= 1'b0;
      prevAct <= 1'b0;
      runLen  <= '0;
      gateHi  <= 1'b0;
      gateLo  <= 1'b0;
    end else if (!active) begin
      prevW   <= 1'b0;
      prevAct <= 1'b0;
      runLen  <= '0;
      gateHi  <= 1'b0;
      gateLo  <= 1'b0;
    end else begin
      prevW   <= want;
      prevAct <= 1'b1;
      runLen  <= runNext;
      gateHi  <= want && settled;
      gateLo  <= !want && settled;
    end
  end

  // R5
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(gateHi && gateLo));

  // R5
  hi_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    gateHi |=> !gateLo);

  // R5
  lo_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    gateLo |=> !gateHi);

endmodule

// File: rtl/fbridge_phase_gen.sv
module fbridge_phase_gen
  import fbg_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int PER_MIN = 8,
  parameter int DT_LV   = 2,
  parameter int DT_HV   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             hvMode,
  input  logic             syncIn,
  input  logic [CNT_W-1:0] periodIn,
  input  logic [CNT_W-1:0] phaseIn,
  output logic             gateHiA,
  output logic             gateLoA,
  output logic             gateHiB,
  output logic             gateLoB
);

  localparam int N_HALF = 2;

  fbgStrobe_t        strb;
  logic              lastTick;
  logic              legActive;
  logic [N_HALF-1:0] want;
  logic [N_HALF-1:0] gHi;
  logic [N_HALF-1:0] gLo;

  fbg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (runEn),
    .syncIn    (syncIn),
    .lastTick  (lastTick),
    .strb      (strb),
    .legActive (legActive)
  );

  fbg_datapath #(
    .CNT_W   (CNT_W),
    .PER_MIN (PER_MIN)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .periodIn (periodIn),
    .phaseIn  (phaseIn),
    .lastTick (lastTick),
    .wantA    (want[0]),
    .wantB    (want[1])
  );

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    fbg_leg #(
      .DT_LV (DT_LV),
      .DT_HV (DT_HV)
    ) u_leg (
      .clk    (clk),
      .rstN   (rstN),
      .active (legActive),
      .hvMode (hvMode),
      .want   (want[h]),
      .gateHi (gHi[h]),
      .gateLo (gLo[h])
    );
  end

  assign gateHiA = gHi[0];
  assign gateLoA = gLo[0];
  assign gateHiB = gHi[1];
  assign gateLoB = gLo[1];

  // R6
  disable_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !(gateHiA || gateLoA || gateHiB || gateLoB));

endmodule

// File: tb/sim_fbridge_phase_gen.sv
`timescale 1ns/1ps
module sim_fbridge_phase_gen;

  localparam int CNT_W   = 10;
  localparam int PER_MIN = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             runEn = 1'b0;
  logic             hvMode = 1'b0;
  logic             syncIn = 1'b0;
  logic [CNT_W-1:0] periodIn = 10'd20;
  logic [CNT_W-1:0] phaseIn = 10'd0;
  logic gateHiA, gateLoA, gateHiB, gateLoB;

  always #10 clk = ~clk;

  fbridge_phase_gen u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .hvMode(hvMode), .syncIn(syncIn),
    .periodIn(periodIn), .phaseIn(phaseIn),
    .gateHiA(gateHiA), .gateLoA(gateLoA), .gateHiB(gateHiB), .gateLoB(gateLoB)
  );

  int    nChk = 0;
  int    nFail = 0;
  string curReq = "R9";
  bit    done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int  mRun, mCnt, mPer, mHalf, mPh;
  bit  histA[$];
  bit  histB[$];
  bit  eHA, eLA, eHB, eLB;

  function automatic bit held(bit q[$], int n, bit v);
    if (q.size() < n) return 1'b0;
    for (int i = q.size() - n; i < q.size(); i++)
      if (q[i] != v) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 0; mCnt = 0; mPer = PER_MIN; mHalf = PER_MIN / 2; mPh = 0;
      histA.delete(); histB.delete();
      eHA = 0; eLA = 0; eHB = 0; eLB = 0;
    end else begin
      automatic bit act = runEn && (mRun != 0);
      automatic bit wA  = (mCnt < mHalf);
      automatic bit wB  = (((mCnt - mPh + mPer) % mPer) < mHalf);
      automatic int dt  = hvMode ? 4 : 2;
      if (act) begin
        histA.push_back(wA);
        histB.push_back(wB);
        if (histA.size() > 8) void'(histA.pop_front());
        if (histB.size() > 8) void'(histB.pop_front());
        eHA = held(histA, dt + 1, 1'b1);
        eLA = held(histA, dt + 1, 1'b0);
        eHB = held(histB, dt + 1, 1'b1);
        eLB = held(histB, dt + 1, 1'b0);
      end else begin
        histA.delete(); histB.delete();
        eHA = 0; eLA = 0; eHB = 0; eLB = 0;
      end
      if (!runEn) begin
        mRun = 0; mCnt = 0;
      end else if (mRun == 0 || syncIn || mCnt == mPer - 1) begin
        mPer  = (int'(periodIn) < PER_MIN) ? PER_MIN : int'(periodIn);
        mHalf = mPer / 2;
        mPh   = (int'(phaseIn) > mHalf) ? mHalf : int'(phaseIn);
        mCnt  = 0;
        mRun  = 1;
      end else begin
        mCnt++;
      end
    end
  end

  // ---------------- per-cycle comparison and monitors ----------------
  int  cyc = 0;
  int  riseA = -1, riseAPrev = -1;
  bit  pHiA = 0;
  int  gapCnt = 0, gapA = -1;
  bit  gapOn = 0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      chk({gateHiA, gateLoA, gateHiB, gateLoB} == {eHA, eLA, eHB, eLB}, curReq,
          int'({gateHiA, gateLoA, gateHiB, gateLoB}), int'({eHA, eLA, eHB, eLB}));
      chk(!(gateHiA && gateLoA) && !(gateHiB && gateLoB), "R5",
          int'({gateHiA, gateLoA, gateHiB, gateLoB}), 0);
    end
    if (gateHiA && !pHiA) begin
      riseAPrev = riseA;
      riseA = cyc;
    end
    if (pHiA && !gateHiA) begin
      gapOn = 1; gapCnt = 1;
    end else if (gapOn && !gateLoA) begin
      gapCnt++;
    end else if (gapOn && gateLoA) begin
      gapA = gapCnt; gapOn = 0;
    end
    pHiA = gateHiA;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] lfsr = 16'hACE1;
    step(3);
    // R9: reset state
    chk({gateHiA, gateLoA, gateHiB, gateLoB} == 4'b0, "R9",
        int'({gateHiA, gateLoA, gateHiB, gateLoB}), 0);
    rstN = 1'b1;
    step(2);
    chk({gateHiA, gateLoA, gateHiB, gateLoB} == 4'b0, "R9",
        int'({gateHiA, gateLoA, gateHiB, gateLoB}), 0);

    // R2 / R4: low-voltage dead time, P = 20, ph = 5
    curReq = "R2"; periodIn = 10'd20; phaseIn = 10'd5; hvMode = 1'b0; runEn = 1'b1;
    gapA = -1;
    step(100);
    chk(riseA - riseAPrev == 20, "R1", riseA - riseAPrev, 20);
    chk(gapA == 2, "R4", gapA, 2);

    // R4: high-voltage dead time
    curReq = "R4"; hvMode = 1'b1; gapA = -1;
    step(100);
    chk(gapA == 4, "R4", gapA, 4);

    // R3: phase above half period is clamped
    curReq = "R3"; phaseIn = 10'd15; hvMode = 1'b0;
    step(80);
    phaseIn = 10'd0;
    step(60);
    chk(gateHiA == gateHiB && gateLoA == gateLoB, "R3",
        int'({gateHiB, gateLoB}), int'({gateHiA, gateLoA}));

    // R1: stepped sweep, words change mid-period
    curReq = "R1"; phaseIn = 10'd7;
    for (int k = 0; k < 10; k++) begin
      periodIn = CNT_W'(60 - 4 * k);
      step(9);
    end
    periodIn = 10'd24;
    step(120);
    chk(riseA - riseAPrev == 24, "R1", riseA - riseAPrev, 24);

    // R8: period below floor
    curReq = "R8"; periodIn = 10'd3; phaseIn = 10'd1;
    step(60);
    chk(riseA - riseAPrev == PER_MIN, "R8", riseA - riseAPrev, PER_MIN);

    // R7: sync pulses at arbitrary points
    curReq = "R7"; periodIn = 10'd30; phaseIn = 10'd9;
    for (int k = 0; k < 8; k++) begin
      step(13 + k);
      syncIn = 1'b1;
      step(1);
      syncIn = 1'b0;
    end
    step(40);

    // R6: enable drop mid-period
    curReq = "R6";
    step(7);
    runEn = 1'b0;
    step(1);
    chk({gateHiA, gateLoA, gateHiB, gateLoB} == 4'b0, "R6",
        int'({gateHiA, gateLoA, gateHiB, gateLoB}), 0);
    step(5);
    runEn = 1'b1;
    step(2);
    chk({gateHiA, gateLoA, gateHiB, gateLoB} == 4'b0, "R6",
        int'({gateHiA, gateLoA, gateHiB, gateLoB}), 0);
    step(60);

    // R4: mixed stimulus
    curReq = "R4";
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'd5) hvMode = ~hvMode;
      syncIn = (lfsr[15:11] == 5'd0);
      runEn  = (lfsr[9:5] != 5'd3);
      if (lfsr[2:0] == 3'd0) periodIn = CNT_W'(4 + lfsr[10:5]);
      if (lfsr[2:0] == 3'd1) phaseIn  = CNT_W'(lfsr[12:7]);
      step(1);
    end
    syncIn = 1'b0; runEn = 1'b1;
    step(20);
    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule